// File: doc/BRIEF.md
# Stream Page Firing Controller

This block decides when one compute page fires. The page has three input streams and three output streams, and each stream uses a valid/ready handshake. The page's control state machine sits in one state at a time. Each state carries a single firing signature made of two masks. The first mask lists the input streams that must hold a token. The second lists the output streams that will receive one.

The controller raises one `fire` strobe when every listed input is valid and every listed output is ready. In that cycle it accepts exactly the listed inputs, presents exactly the listed outputs, and moves the state machine to its next state. In any other cycle nothing moves. Availability and space are both checked before the firing, so a firing can never stall halfway through its I/O.

The signature table is computed from the state number. A small test datapath drives the output data. It can sum the required inputs, or it can pass inputs through.

Top module: `page_fire_ctrl`

## Requirements
- R1: While `rst` is high, `fire`, `in_ready` and `out_valid` are all 0. The first clock edge with `rst` high sets `state` to 0.
- R2: In state s, input stream i (bit i, A=0, B=1, C=2) is required when bit i of (s mod 8) is 1. Output stream j (X=0, Y=1, Z=2) is produced when bit j of ((5*s) mod 8) is 1.
- R3: `fire` is 1 exactly when every required input has `in_valid` high and every produced output has `out_ready` high.
- R4: The `in_valid` and `out_ready` bits of streams outside the current signature have no effect on `fire`.
- R5: `in_ready` equals the required-input mask in a firing cycle and is 0 in every other cycle.
- R6: `out_valid` equals the produced-output mask in a firing cycle and is 0 in every other cycle.
- R7: At the clock edge after a firing cycle, `state` becomes (state+1) mod 8. In every other cycle it holds its value.
- R8: A state whose two masks are both empty (state 0) fires in every cycle out of reset, whatever the handshake inputs are.
- R9: In the default sum mode, output j carries (sum of the 8-bit data of the required inputs + j) mod 256 whenever it is valid.
- R10: If any produced output is not ready, no input is accepted, even when all required inputs are valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 3 | Token present on input streams A, B, C (bits 0, 1, 2) |
| in_ready | output | 3 | Token taken from each input stream this cycle |
| in_data | input | 3x8 | Input token data, one byte per stream |
| out_valid | output | 3 | Token presented on output streams X, Y, Z (bits 0, 1, 2) |
| out_ready | input | 3 | Space available on each output stream |
| out_data | output | 3x8 | Output token data, one byte per stream |
| fire | output | 1 | The page fires in this cycle |
| state | output | 3 | Current state of the page state machine |

## Verification
The bench steers the page into each of the eight states. In each state it applies all 64 combinations of the three input-valid bits and the three output-ready bits. Combinations that differ only in bits outside the signature show that unrelated streams do not matter. Combinations where the inputs are satisfied but an output is blocked separate back-pressure stalls from missing-token stalls. The empty-signature state shows firing with no handshake condition at all. Varying the input bytes from one cycle to the next checks the summed output data against arithmetic done in the bench. A state read after every edge confirms that the state advances on a firing and holds otherwise.

// File: rtl/page_fire_pkg.sv
package page_fire_pkg;
  localparam int unsigned DEF_NUM_IN     = 3;
  localparam int unsigned DEF_NUM_OUT    = 3;
  localparam int unsigned DEF_DW         = 8;
  localparam int unsigned DEF_NUM_STATES = 8;
  localparam int unsigned DEF_OUT_MULT   = 5;

  typedef enum logic [0:0] {
    DP_SUM  = 1'b0,
    DP_PASS = 1'b1
  } dp_mode_e;
endpackage

// File: rtl/page_sig_table.sv
module page_sig_table #(
  parameter int unsigned NUM_STATES = 8,
  parameter int unsigned NUM_IN     = 3,
  parameter int unsigned NUM_OUT    = 3,
  parameter int unsigned OUT_MULT   = 5,
  localparam int unsigned SW        = $clog2(NUM_STATES)
) (
  input  logic [SW-1:0]      cur_state,
  output logic [NUM_IN-1:0]  need_in,
  output logic [NUM_OUT-1:0] make_out,
  output logic [SW-1:0]      succ_state
);
  localparam int unsigned IN_SPAN  = 1 << NUM_IN;
  localparam int unsigned OUT_SPAN = 1 << NUM_OUT;

  logic [NUM_IN-1:0]  tbl_in  [NUM_STATES];
  logic [NUM_OUT-1:0] tbl_out [NUM_STATES];
  logic [SW-1:0]      tbl_nxt [NUM_STATES];

  // One signature per state, derived arithmetically from the state index.
  for (genvar s = 0; s < NUM_STATES; s++) begin : g_sig
    localparam logic [31:0] IM = 32'(s % IN_SPAN);
    localparam logic [31:0] OM = 32'((s * OUT_MULT) % OUT_SPAN);
    localparam logic [31:0] NX = 32'((s + 1) % NUM_STATES);
    assign tbl_in[s]  = IM[NUM_IN-1:0];
    assign tbl_out[s] = OM[NUM_OUT-1:0];
    assign tbl_nxt[s] = NX[SW-1:0];
  end

  assign need_in    = tbl_in[cur_state];
  assign make_out   = tbl_out[cur_state];
  assign succ_state = tbl_nxt[cur_state];
endmodule

// File: rtl/page_fire_gate.sv
module page_fire_gate #(
  parameter int unsigned NUM_IN  = 3,
  parameter int unsigned NUM_OUT = 3
) (
  input  logic               enable,
  input  logic [NUM_IN-1:0]  need_in,
  input  logic [NUM_OUT-1:0] make_out,
  input  logic [NUM_IN-1:0]  tok_present,
  input  logic [NUM_OUT-1:0] space_free,
  output logic               go,
  output logic [NUM_IN-1:0]  take,
  output logic [NUM_OUT-1:0] give
);
  logic [NUM_IN-1:0]  in_ok;
  logic [NUM_OUT-1:0] out_ok;

  // A stream outside the signature counts as satisfied.
  for (genvar i = 0; i < NUM_IN; i++) begin : g_in
    assign in_ok[i] = ~need_in[i] | tok_present[i];
  end
  for (genvar j = 0; j < NUM_OUT; j++) begin : g_out
    assign out_ok[j] = ~make_out[j] | space_free[j];
  end

  assign go   = enable & (&in_ok) & (&out_ok);
  assign take = need_in  & {NUM_IN{go}};
  assign give = make_out & {NUM_OUT{go}};
endmodule

// File: rtl/page_datapath.sv
module page_datapath
  import page_fire_pkg::*;
#(
  parameter int unsigned NUM_IN  = 3,
  parameter int unsigned NUM_OUT = 3,
  parameter int unsigned DW      = 8,
  parameter dp_mode_e    MODE    = DP_SUM
) (
  input  logic [NUM_IN-1:0]           need_in,
  input  logic [NUM_IN-1:0][DW-1:0]   src,
  output logic [NUM_OUT-1:0][DW-1:0]  dst
);
  if (MODE == DP_SUM) begin : g_sum
    logic [DW-1:0] acc;
    always_comb begin
      acc = '0;
      for (int i = 0; i < NUM_IN; i++) begin
        if (need_in[i]) acc = acc + src[i];
      end
    end
    for (genvar j = 0; j < NUM_OUT; j++) begin : g_o
      localparam logic [31:0] OFS = 32'(j);
      assign dst[j] = acc + OFS[DW-1:0];
    end
  end else begin : g_pass
    for (genvar j = 0; j < NUM_OUT; j++) begin : g_o
      assign dst[j] = src[j % NUM_IN];
    end
  end
endmodule

// File: rtl/page_state_reg.sv
module page_state_reg #(
  parameter int unsigned SW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic [SW-1:0] succ,
  output logic [SW-1:0] cur
);
  always_ff @(posedge clk) begin
    if (rst)       cur <= '0;
    else if (step) cur <= succ;
  end
endmodule

// File: rtl/page_fire_ctrl.sv
module page_fire_ctrl
  import page_fire_pkg::*;
#(
  parameter int unsigned NUM_IN     = DEF_NUM_IN,
  parameter int unsigned NUM_OUT    = DEF_NUM_OUT,
  parameter int unsigned DW         = DEF_DW,
  parameter int unsigned NUM_STATES = DEF_NUM_STATES,
  parameter int unsigned OUT_MULT   = DEF_OUT_MULT,
  parameter dp_mode_e    MODE       = DP_SUM,
  localparam int unsigned SW        = $clog2(NUM_STATES)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_IN-1:0]           in_valid,
  output logic [NUM_IN-1:0]           in_ready,
  input  logic [NUM_IN-1:0][DW-1:0]   in_data,
  output logic [NUM_OUT-1:0]          out_valid,
  input  logic [NUM_OUT-1:0]          out_ready,
  output logic [NUM_OUT-1:0][DW-1:0]  out_data,
  output logic                        fire,
  output logic [SW-1:0]               state
);
  logic [NUM_IN-1:0]  need_in;
  logic [NUM_OUT-1:0] make_out;
  logic [SW-1:0]      succ_state;

  page_sig_table #(
    .NUM_STATES(NUM_STATES), .NUM_IN(NUM_IN),
    .NUM_OUT(NUM_OUT), .OUT_MULT(OUT_MULT)
  ) sig_i (
    .cur_state(state), .need_in(need_in),
    .make_out(make_out), .succ_state(succ_state)
  );

  page_fire_gate #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) gate_i (
    .enable(~rst), .need_in(need_in), .make_out(make_out),
    .tok_present(in_valid), .space_free(out_ready),
    .go(fire), .take(in_ready), .give(out_valid)
  );

  page_datapath #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .DW(DW), .MODE(MODE)) dp_i (
    .need_in(need_in), .src(in_data), .dst(out_data)
  );

  page_state_reg #(.SW(SW)) st_i (
    .clk(clk), .rst(rst), .step(fire), .succ(succ_state), .cur(state)
  );

  // R1: quiet handshake while in reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |-> (!fire && in_ready == '0 && out_valid == '0));

  // R3: a firing needs every required token present
  p_fire_tokens_r3: assert property (@(posedge clk) disable iff (rst)
    fire |-> ((in_valid & need_in) == need_in));

  // R3: a firing needs space on every produced output
  p_fire_space_r3: assert property (@(posedge clk) disable iff (rst)
    fire |-> ((out_ready & make_out) == make_out));

  // R5: inputs are taken only in a firing cycle
  p_take_only_on_fire_r5: assert property (@(posedge clk) disable iff (rst)
    (in_ready != '0) |-> fire);

  // R6: outputs are offered only in a firing cycle
  p_give_only_on_fire_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid != '0) |-> fire);

  // R7: state holds without a firing
  p_state_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(state));

  // R7: state steps on a firing
  p_state_step_r7: assert property (@(posedge clk) disable iff (rst)
    fire |=> (state == $past(succ_state)));

  // R8: empty signature always fires
  p_empty_fires_r8: assert property (@(posedge clk) disable iff (rst)
    (need_in == '0 && make_out == '0) |-> fire);

  // R10: a blocked output stalls every input
  p_backpressure_r10: assert property (@(posedge clk) disable iff (rst)
    ((out_ready & make_out) != make_out) |-> (in_ready == '0));
endmodule

// File: tb/page_fire_ctrl_tb_top.sv
module page_fire_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] in_valid = '0;
  logic [2:0] in_ready;
  logic [2:0][7:0] in_data = '0;
  logic [2:0] out_valid;
  logic [2:0] out_ready = '0;
  logic [2:0][7:0] out_data;
  logic fire;
  logic [2:0] state;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  int k = 0;
  logic [2:0] ms = '0;

  always #10 clk = ~clk;

  page_fire_ctrl dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .fire(fire), .state(state)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h (state %0d)", tag, act, exp, ms);
    end
  endtask

  function automatic logic [2:0] m_in(input logic [2:0] s);
    return s;
  endfunction
  function automatic logic [2:0] m_out(input logic [2:0] s);
    return 3'((5 * int'(s)) % 8);
  endfunction

  task automatic set_data();
    for (int i = 0; i < 3; i++) in_data[i] = 8'((k * 37 + i * 91 + 13) % 256);
    k++;
  endtask

  // Drive a pattern, check the combinational result, step one clock.
  task automatic apply(input logic [2:0] pv, input logic [2:0] pr, input bit nav);
    logic [2:0] im, om;
    bit ef;
    int sum;
    im = m_in(ms);
    om = m_out(ms);
    in_valid = pv;
    out_ready = pr;
    set_data();
    #1;
    ef = ((pv & im) == im) && ((pr & om) == om);
    if (ms == 3'd0)
      check(fire == 1'b1, "R8", fire, 1);
    else if (((pv & ~im) != 0 || (pr & ~om) != 0))
      check(fire == ef, "R4", fire, ef);
    else
      check(fire == ef, "R3", fire, ef);
    if (nav) begin
      check(in_ready == im, "R2", in_ready, im);
      check(out_valid == om, "R2", out_valid, om);
    end else begin
      check(in_ready == (ef ? im : 3'b0), "R5", in_ready, ef ? im : 3'b0);
      check(out_valid == (ef ? om : 3'b0), "R6", out_valid, ef ? om : 3'b0);
      if (((pv & im) == im) && ((pr & om) != om))
        check(in_ready == 3'b0, "R10", in_ready, 0);
    end
    sum = 0;
    for (int i = 0; i < 3; i++) if (im[i]) sum += int'(in_data[i]);
    for (int j = 0; j < 3; j++)
      if (ef && om[j]) check(out_data[j] == 8'((sum + j) % 256), "R9",
                             out_data[j], (sum + j) % 256);
    @(posedge clk);
    if (ef) ms = ms + 3'd1;
    @(negedge clk);
    #1;
    check(state == ms, "R7", state, ms);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset with every handshake input high
    rst = 1'b1;
    in_valid = 3'b111;
    out_ready = 3'b111;
    @(negedge clk);
    #1;
    check(fire == 1'b0, "R1", fire, 0);
    check(in_ready == 3'b0, "R1", in_ready, 0);
    check(out_valid == 3'b0, "R1", out_valid, 0);
    @(negedge clk);
    check(state == 3'd0, "R1", state, 0);
    rst = 1'b0;
    ms = '0;
    #1;

    for (int s = 0; s < 8; s++) begin
      for (int p = 0; p < 64; p++) begin
        while (ms != 3'(s)) apply(3'b111, 3'b111, 1'b1);
        apply(3'(p), 3'(p >> 3), 1'b0);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule